// File: doc/BRIEF.md
# Address Translation Buffer with Reference and Dirty Tracking

This block caches recent page translations for a processor pipeline. Pages are fixed at 4 KiB. Each lookup splits the virtual address into a page number and a 12-bit offset. All stored tags are checked at once, and on a hit the block returns the physical address in the same cycle. Every lookup result is one of three kinds: a hit, a miss, or a protection fault. The block also gives a write-back enable. The pipeline uses it to suppress the destination register write, so that a faulting instruction can be restarted once the miss handler has done its work.

Each entry carries a reference bit and a dirty bit. A successful access sets the reference bit, and a successful write also sets the dirty bit. When a lookup hits, the stored bits of that entry, as they stood before the access, come back with the result. A periodic clear command drops every reference bit to zero.

A separate refill port installs the translation supplied by the miss handler. The refill overwrites an entry that already holds the same page number. Otherwise it picks a victim: an empty slot first, then a slot that has not been referenced, and finally a slot named by a rotating pointer.

Top module: `xlat_buffer`

## Requirements
- R1: Virtual address bits [31:12] form the page number and bits [11:0] pass through untranslated. On a hit, `lk_paddr` equals {stored physical page, bits [11:0]} in the same cycle as the request. When there is no hit, `lk_paddr` is 0.
- R2: Any of the 16 entries can hold any page number, and a lookup finds the page whichever entry holds it.
- R3: A hit (valid match, no fault) sets the matched entry's reference bit at the next clock edge. While a lookup hits, `lk_ref` and `lk_dirty` show that entry's bits as they stood before this access.
- R4: A write hit (`lk_write`=1) also sets the matched entry's dirty bit. A read hit leaves the dirty bit unchanged.
- R5: A valid lookup that matches no valid entry raises `lk_miss` in the same cycle. In that cycle `lk_hit` and `lk_wb` are 0 and no status bit changes. With `lk_valid`=0, all result outputs are 0.
- R6: `clear_ref` sets every reference bit to 0 at the clock edge. A hit in the same cycle still leaves its own entry's reference bit at 1.
- R7: A matched entry installed with `refill_super`=1, looked up with `lk_super`=0, raises `lk_fault` instead of `lk_hit`. In that case `lk_wb` is 0 and no status bit changes. With `lk_super`=1 the same lookup hits.
- R8: A refill of a new page number goes into the lowest-numbered invalid entry.
- R9: When every entry is valid, a refill goes into the lowest-numbered entry whose reference bit is 0.
- R10: When every entry is valid and referenced, a refill goes into the entry named by a rotating pointer. The pointer is 0 after reset and moves up by one, wrapping, each time it is used.
- R11: A refill whose page number matches a valid entry overwrites that entry, so no two valid entries share a tag.
- R12: A synchronous reset (`rst`=1 at a clock edge) invalidates every entry and returns the rotating pointer to 0.
- R13: A refilled entry starts with its reference and dirty bits at 0. A lookup in the same cycle as a refill sees the buffer contents from before the refill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a write |
| lk_super | input | 1 | Requester runs in supervisor mode |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No valid entry matches |
| lk_fault | output | 1 | User access to a supervisor-only page |
| lk_wb | output | 1 | Result write-back may proceed |
| lk_paddr | output | 32 | Translated physical address |
| lk_ref | output | 1 | Reference bit of the hit entry before this access |
| lk_dirty | output | 1 | Dirty bit of the hit entry before this access |
| refill_valid | input | 1 | Install a translation |
| refill_vpn | input | 20 | Page number to install |
| refill_ppn | input | 20 | Physical page to install |
| refill_super | input | 1 | Installed page is supervisor-only |
| clear_ref | input | 1 | Clear all reference bits |

## Verification
Status bits can change for more than one reason in the same cycle. A lookup hit may coincide with the periodic reference clear, and a lookup may coincide with a refill that targets the very entry being read. The bench drives these pairs together on purpose: hits are issued in the same cycle as `clear_ref`, and refills are issued alongside lookups of the page that is being replaced. A cycle-by-cycle behavioural model, written from the requirements, then predicts every output, including the reported reference and dirty bits. These bits expose which update took priority on a later lookup.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int DEF_VA_W      = 32;
   localparam int DEF_PA_W      = 32;
   localparam int DEF_PAGE_BITS = 12;
   localparam int DEF_ENTRIES   = 16;

   typedef enum logic [1:0] {
      VICT_EMPTY = 2'd0,
      VICT_COLD  = 2'd1,
      VICT_ROT   = 2'd2
   } vict_src_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]            valid_i,
   input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
   input  logic [TAG_W-1:0]              key_i,
   output logic [ENTRIES-1:0]            match_o,
   output logic                          any_o,
   output logic [IDX_W-1:0]              idx_o
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match_o[e] = valid_i[e] && (tags_i[e] == key_i);
   end

   assign any_o = |match_o;

   always_comb begin
      idx_o = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (match_o[e]) idx_o = IDX_W'(e);
      end
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [ENTRIES-1:0] ref_i,
   input  logic [IDX_W-1:0]   rot_i,
   output logic [IDX_W-1:0]   idx_o,
   output vict_src_e          src_o
);
   logic [ENTRIES-1:0] empty_v, cold_v;
   logic [IDX_W-1:0]   empty_idx, cold_idx;

   assign empty_v = ~valid_i;
   assign cold_v  = ~ref_i;

   always_comb begin
      empty_idx = '0;
      cold_idx  = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (empty_v[e]) empty_idx = IDX_W'(e);
         if (cold_v[e])  cold_idx  = IDX_W'(e);
      end
   end

   always_comb begin
      if (|empty_v) begin
         src_o = VICT_EMPTY;
         idx_o = empty_idx;
      end else if (|cold_v) begin
         src_o = VICT_COLD;
         idx_o = cold_idx;
      end else begin
         src_o = VICT_ROT;
         idx_o = rot_i;
      end
   end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
   import xlat_pkg::*;
#(
   parameter int VA_W      = DEF_VA_W,
   parameter int PA_W      = DEF_PA_W,
   parameter int PAGE_BITS = DEF_PAGE_BITS,
   parameter int ENTRIES   = DEF_ENTRIES,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PPN_W    = PA_W - PAGE_BITS,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             lk_write,
   input  logic             lk_super,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic             lk_fault,
   output logic             lk_wb,
   output logic [PA_W-1:0]  lk_paddr,
   output logic             lk_ref,
   output logic             lk_dirty,
   input  logic             refill_valid,
   input  logic [VPN_W-1:0] refill_vpn,
   input  logic [PPN_W-1:0] refill_ppn,
   input  logic             refill_super,
   input  logic             clear_ref
);
   // elaboration-time parameter checks
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("xlat_buffer: ENTRIES must be a power of two, at least 2");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("xlat_buffer: PAGE_BITS must be smaller than both address widths");
   end

   // entry storage
   logic [ENTRIES-1:0]            valid_q, ref_q, dirty_q, sup_q;
   logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
   logic [IDX_W-1:0]              rot_q;

   // lookup path
   logic [VPN_W-1:0]   lk_vpn;
   logic [ENTRIES-1:0] lk_match;
   logic               lk_any;
   logic [IDX_W-1:0]   lk_idx;
   logic               lk_denied;

   assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];

   xlat_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
      .valid_i (valid_q),
      .tags_i  (tag_q),
      .key_i   (lk_vpn),
      .match_o (lk_match),
      .any_o   (lk_any),
      .idx_o   (lk_idx)
   );

   assign lk_denied = sup_q[lk_idx] && !lk_super;
   assign lk_hit    = lk_valid && lk_any && !lk_denied;
   assign lk_fault  = lk_valid && lk_any && lk_denied;
   assign lk_miss   = lk_valid && !lk_any;
   assign lk_wb     = lk_hit;
   assign lk_paddr  = lk_hit ? {ppn_q[lk_idx], lk_vaddr[PAGE_BITS-1:0]} : '0;
   assign lk_ref    = lk_hit && ref_q[lk_idx];
   assign lk_dirty  = lk_hit && dirty_q[lk_idx];

   // refill path
   logic [ENTRIES-1:0] rf_match;
   logic               rf_any;
   logic [IDX_W-1:0]   rf_match_idx, vict_idx, rf_idx;
   vict_src_e          vict_src;

   xlat_match #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_rf_match (
      .valid_i (valid_q),
      .tags_i  (tag_q),
      .key_i   (refill_vpn),
      .match_o (rf_match),
      .any_o   (rf_any),
      .idx_o   (rf_match_idx)
   );

   xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
      .valid_i (valid_q),
      .ref_i   (ref_q),
      .rot_i   (rot_q),
      .idx_o   (vict_idx),
      .src_o   (vict_src)
   );

   assign rf_idx = rf_any ? rf_match_idx : vict_idx;

   // rotating pointer
   always_ff @(posedge clk) begin
      if (rst) begin
         rot_q <= '0;
      end else if (refill_valid && !rf_any && vict_src == VICT_ROT) begin
         rot_q <= rot_q + 1'b1;
      end
   end

   // entry state: refill beats access update, access update beats clear
   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
         ref_q   <= '0;
         dirty_q <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (refill_valid && rf_idx == IDX_W'(e)) begin
               valid_q[e] <= 1'b1;
               ref_q[e]   <= 1'b0;
               dirty_q[e] <= 1'b0;
            end else if (lk_hit && lk_idx == IDX_W'(e)) begin
               ref_q[e] <= 1'b1;
               if (lk_write) dirty_q[e] <= 1'b1;
            end else if (clear_ref) begin
               ref_q[e] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < ENTRIES; e++) begin
         if (!rst && refill_valid && rf_idx == IDX_W'(e)) begin
            tag_q[e] <= refill_vpn;
            ppn_q[e] <= refill_ppn;
            sup_q[e] <= refill_super;
         end
      end
   end
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
   parameter int ENTRIES   = 16,
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst,
   input logic               lk_valid,
   input logic               lk_write,
   input logic [VA_W-1:0]    lk_vaddr,
   input logic               lk_hit,
   input logic               lk_miss,
   input logic               lk_fault,
   input logic               lk_wb,
   input logic [PA_W-1:0]    lk_paddr,
   input logic               refill_valid,
   input logic               clear_ref,
   input logic [ENTRIES-1:0] valid_q,
   input logic [ENTRIES-1:0] ref_q,
   input logic [ENTRIES-1:0] dirty_q,
   input logic [ENTRIES-1:0] lk_match,
   input logic [IDX_W-1:0]   lk_idx
);
   assert_offset_R1: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

   assert_ref_set_R3: assert property (@(posedge clk) disable iff (rst)
      (lk_hit && !refill_valid) |=> ref_q[$past(lk_idx)]);

   assert_dirty_set_R4: assert property (@(posedge clk) disable iff (rst)
      (lk_hit && lk_write && !refill_valid) |=> dirty_q[$past(lk_idx)]);

   assert_one_result_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0({lk_hit, lk_miss, lk_fault}));

   assert_miss_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
      lk_miss |-> !lk_wb);

   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      !lk_valid |-> !(lk_hit || lk_miss || lk_fault || lk_wb));

   assert_clear_all_R6: assert property (@(posedge clk) disable iff (rst)
      (clear_ref && !lk_hit && !refill_valid) |=> ref_q == '0);

   assert_fault_blocks_R7: assert property (@(posedge clk) disable iff (rst)
      lk_fault |-> (!lk_hit && !lk_wb));

   assert_unique_tag_R11: assert property (@(posedge clk) disable iff (rst)
      $countones(lk_match) <= 1);

   assert_reset_clears_R12: assert property (@(posedge clk)
      rst |=> valid_q == '0);
endmodule

bind xlat_buffer xlat_buffer_chk #(
   .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
   .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
   .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
   .lk_fault(lk_fault), .lk_wb(lk_wb), .lk_paddr(lk_paddr),
   .refill_valid(refill_valid), .clear_ref(clear_ref),
   .valid_q(valid_q), .ref_q(ref_q), .dirty_q(dirty_q),
   .lk_match(lk_match), .lk_idx(lk_idx)
);

// File: tb/xlat_buffer_test.sv
module xlat_buffer_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        lk_valid = 0, lk_write = 0, lk_super = 0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit, lk_miss, lk_fault, lk_wb, lk_ref, lk_dirty;
   logic [31:0] lk_paddr;
   logic        refill_valid = 0, refill_super = 0, clear_ref = 0;
   logic [19:0] refill_vpn = '0, refill_ppn = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;   // 250 MHz

   xlat_buffer uut (
      .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .lk_write(lk_write), .lk_super(lk_super), .lk_hit(lk_hit),
      .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_wb(lk_wb),
      .lk_paddr(lk_paddr), .lk_ref(lk_ref), .lk_dirty(lk_dirty),
      .refill_valid(refill_valid), .refill_vpn(refill_vpn),
      .refill_ppn(refill_ppn), .refill_super(refill_super),
      .clear_ref(clear_ref)
   );

   // behavioural model
   bit          m_v[16], m_ref[16], m_dirty[16], m_sup[16];
   logic [19:0] m_tag[16], m_ppn[16];
   int          m_rot = 0;

   function automatic int model_find(logic [19:0] vpn);
      int r = -1;
      for (int i = 0; i < 16; i++) if (m_v[i] && m_tag[i] == vpn) r = i;
      return r;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 16; i++) begin
         m_v[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
      end
      m_rot = 0;
   endtask

   task automatic step(string tag, bit v, logic [31:0] va, bit w, bit s,
                       bit rf, logic [19:0] rvpn, logic [19:0] rppn,
                       bit rsup, bit clr);
      int m, tgt;
      bit e_hit, e_miss, e_fault, e_ref, e_dirty;
      logic [31:0] e_pa;
      lk_valid = v; lk_vaddr = va; lk_write = w; lk_super = s;
      refill_valid = rf; refill_vpn = rvpn; refill_ppn = rppn;
      refill_super = rsup; clear_ref = clr;
      #1;
      m       = model_find(va[31:12]);
      e_miss  = v && m < 0;
      e_fault = v && m >= 0 && m_sup[m] && !s;
      e_hit   = v && m >= 0 && !e_fault;
      e_pa    = e_hit ? {m_ppn[m], va[11:0]} : 32'h0;
      e_ref   = e_hit && m_ref[m];
      e_dirty = e_hit && m_dirty[m];
      checks++;
      if (lk_hit !== e_hit || lk_miss !== e_miss || lk_fault !== e_fault ||
          lk_wb !== e_hit || lk_paddr !== e_pa || lk_ref !== e_ref ||
          lk_dirty !== e_dirty) begin
         fails++;
         $display("FAIL %s va=%h: got hit=%b miss=%b fault=%b wb=%b pa=%h ref=%b dirty=%b, expected hit=%b miss=%b fault=%b wb=%b pa=%h ref=%b dirty=%b",
                  tag, va, lk_hit, lk_miss, lk_fault, lk_wb, lk_paddr, lk_ref,
                  lk_dirty, e_hit, e_miss, e_fault, e_hit, e_pa, e_ref, e_dirty);
      end
      @(posedge clk);
      // R13: refill target chosen from pre-edge state
      tgt = -1;
      if (rf) begin
         tgt = model_find(rvpn);                                        // R11
         for (int i = 0; i < 16; i++) if (tgt < 0 && !m_v[i]) tgt = i;   // R8
         for (int i = 0; i < 16; i++) if (tgt < 0 && !m_ref[i]) tgt = i; // R9
         if (tgt < 0) begin tgt = m_rot; m_rot = (m_rot + 1) % 16; end   // R10
      end
      for (int i = 0; i < 16; i++) begin
         if (i == tgt) begin
            m_v[i] = 1; m_tag[i] = rvpn; m_ppn[i] = rppn; m_sup[i] = rsup;
            m_ref[i] = 0; m_dirty[i] = 0;
         end else if (e_hit && i == m) begin
            m_ref[i] = 1;
            if (w) m_dirty[i] = 1;
         end else if (clr) begin
            m_ref[i] = 0;
         end
      end
      @(negedge clk);
   endtask

   task automatic look(string tag, logic [31:0] va, bit w, bit s);
      step(tag, 1, va, w, s, 0, '0, '0, 0, 0);
   endtask

   task automatic fill(string tag, logic [19:0] vpn, logic [19:0] ppn, bit sup);
      step(tag, 0, '0, 0, 0, 1, vpn, ppn, sup, 0);
   endtask

   task automatic do_reset();
      rst = 1; lk_valid = 0; refill_valid = 0; clear_ref = 0;
      @(posedge clk); @(posedge clk);
      model_reset();
      @(negedge clk);
      rst = 0;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R12: empty after reset
      look("R12", 32'h0010_0123, 0, 1);
      step("R5", 0, 32'h0010_0000, 0, 0, 0, '0, '0, 0, 0);
      // R8: fill lowest invalid; entry 5 supervisor-only
      for (int i = 0; i < 16; i++)
         fill("R8", 20'h00100 + 20'(i), 20'h80000 + 20'(i * 3), i == 5);
      // R1 R2: every entry found, varied offsets
      for (int i = 15; i >= 0; i--)
         look("R2", {20'h00100 + 20'(i), 12'(i * 257)}, 0, 1);
      look("R1", 32'h0010_3FFF, 0, 1);
      look("R5", 32'h0020_0000, 0, 1);
      // R4: write hits set dirty, seen on re-lookup
      look("R4", 32'h0010_2010, 1, 0);
      look("R4", 32'h0010_2020, 0, 0);
      look("R4", 32'h0010_3000, 0, 0);
      // R7: supervisor page
      look("R7", 32'h0010_5444, 1, 0);
      look("R7", 32'h0010_5444, 0, 1);
      look("R7", 32'h0010_5444, 0, 1);
      // R6: clear with concurrent hit
      step("R6", 1, 32'h0010_7000, 1, 1, 0, '0, '0, 0, 1);
      look("R6", 32'h0010_7000, 0, 1);
      look("R6", 32'h0010_2000, 0, 1);
      // R9: refill picks lowest unreferenced
      fill("R9", 20'h00300, 20'h0AAAA, 0);
      look("R9", 32'h0030_0ABC, 0, 1);
      look("R9", 32'h0010_0000, 0, 1);
      // R13: lookup same cycle as refill replacing that page
      step("R13", 1, 32'h0010_1004, 0, 1, 1, 20'h00101, 20'h0BEEF, 0, 0);
      look("R13", 32'h0010_1004, 0, 1);
      // R10: all referenced -> rotating pointer, several rounds
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < 16; i++) begin
            int t = model_find(20'h00100 + 20'(i));
            if (t >= 0) look("R10", {20'h00100 + 20'(i), 12'h0}, 0, 1);
         end
         look("R10", 32'h0030_0000, 0, 1);
         for (int k = 0; k < 4; k++) look("R10", {20'h00400 + 20'(k), 12'h0}, 0, 1);
         for (int k = 0; k < 16; k++) if (model_find(20'h00400 + 20'(k)) >= 0)
            look("R10", {20'h00400 + 20'(k), 12'h0}, 0, 1);
         fill("R10", 20'h00400 + 20'(r), 20'h0C000 + 20'(r), 0);
         look("R10", {20'h00400 + 20'(r), 12'h77}, 0, 1);
      end
      // R11: duplicate page overwrites in place
      fill("R11", 20'h00400, 20'h0DDDD, 1);
      look("R11", 32'h0040_0001, 0, 0);
      look("R11", 32'h0040_0002, 1, 1);
      look("R11", 32'h0040_0003, 0, 1);
      // R12: reset mid-run
      do_reset();
      look("R12", 32'h0040_0000, 0, 1);
      fill("R12", 20'h00900, 20'h00001, 0);
      look("R12", 32'h0090_0FFF, 0, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule